// File: doc/BRIEF.md
# Dual-Line Serial Audio Input Frame Receiver

This block receives the input half of a codec serial link where up to two codecs each drive their own serial data line. The lines share one bit clock and one frame sync. The receiver runs on the bit clock and captures all data on its falling edge. A frame begins when the sync line is first seen high. Each frame has a 16-bit tag slot followed by twelve 20-bit slots. Every slot is sent most significant bit first, and positions that carry no data are zero.

The tag slot from each line supplies that line's codec-ready flag and one valid bit for each of slots 1 to 12. For every data slot, the receiver keeps the word from the line that tagged it. When both lines tag the same slot, it keeps the primary line's word and raises a sticky collision flag. After the last bit of each frame it pulses one strobe for each valid audio slot (slots 3 to 12). Each strobe comes with the slot word and the number of the line that supplied it. In the same cycle it pulses a status strobe when slots 1 and 2 are both valid, and it updates the active-low slot-request vector when slot 1 is valid.

Top module: `acl_rx`

## Requirements
- R1: Before the first high sample of `sync_i`, no data is captured. Every low-to-high change of `sync_i` seen on a falling edge restarts the frame at tag bit 0 on the next falling edge, so the edge where the change is seen captures no data and a partly received frame produces no strobes.
- R2: A frame is 256 bits: the 16-bit tag slot, then slots 1 to 12 of 20 bits each, all sent MSB first. `pcm_word_o[i*20 +: 20]` holds the slot i+3 word in its sent bit order.
- R3: `rdy_o[l]` follows bit 15 of the tag slot on line l. It changes only on the falling edge after the last tag bit.
- R4: Tag bit 15-k marks slot k (1..12) as valid. `pcm_stb_o[i]` pulses for exactly one bit clock after the last bit of a frame, and only if slot i+3 was tagged valid on either line in that frame.
- R5: A valid slot's word is taken from the line that tagged it. `pcm_line_o[i]` is 0 for the primary line (`sdi_i[0]`) and 1 for the secondary line.
- R6: If both lines tag the same slot in 1..12, `col_err_o` is set at the end of that slot and stays set until reset. The word and line number then come from the primary line.
- R7: `stat_stb_o` pulses together with the frame-end strobes when slots 1 and 2 are both valid. `stat_idx_o` is then slot 1 bits 18..12 and `stat_data_o` is slot 2 bits 19..4.
- R8: At a frame end with slot 1 valid, `req_n_o[i]` takes slot 1 bit 11-i, which is the active-low request for slot i+3. In any other frame it holds its value. It resets to all ones.
- R9: After 256 captured bits the receiver continues with tag bit 0 of the next frame without needing a new sync edge.
- R10: After reset, `rdy_o`, `col_err_o`, all strobes and the line numbers are 0, and `req_n_o` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared bit clock; all capture happens on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame sync |
| sdi_i | input | N_LINE | Serial data, bit 0 is the primary line |
| rdy_o | output | N_LINE | Per-line codec-ready flag |
| col_err_o | output | 1 | Sticky flag: both lines tagged the same slot |
| pcm_stb_o | output | 10 | Frame-end strobe per audio slot 3..12 |
| pcm_word_o | output | 200 | 20-bit words of slots 3..12 |
| pcm_line_o | output | 10*LINE_W | Source line of each audio slot |
| stat_stb_o | output | 1 | Status word strobe |
| stat_idx_o | output | 7 | Echoed register index |
| stat_data_o | output | 16 | Returned status data |
| req_n_o | output | 10 | Active-low slot requests for slots 3..12 |

## Verification
Two events can land on the same falling edge: a collision on slot 12 and the frame-end strobes. The bench provokes this with a frame in which both lines tag slot 12. The sticky flag then rises on the very edge that the audio and status strobes fire. The behavioural model updates its expected flag at the last bit of every slot and its expected strobes at bit 255, and it compares them on every rising edge. The edge is judged correct only if the flag, the strobe set and the primary line's word all appear together in the following half-period.

// File: rtl/acl_rx_pkg.sv
package acl_rx_pkg;
  localparam int TAG_W   = 16;
  localparam int SLOT_W  = 20;
  localparam int N_SLOT  = 12;
  localparam int PCM_LO  = 3;
  localparam int N_PCM   = N_SLOT - PCM_LO + 1;
  localparam int IDX_W   = 7;
  localparam int IDX_HI  = 18;
  localparam int STAT_W  = 16;
  localparam int STAT_LO = SLOT_W - STAT_W;
  localparam int REQ_HI  = 11;
  localparam int REQ_LO  = REQ_HI - N_PCM + 1;
  localparam int SLOT_IW = $clog2(N_SLOT + 1);
  localparam int BIT_IW  = $clog2(SLOT_W);

  typedef logic [SLOT_W-1:0]  word_t;
  typedef logic [SLOT_IW-1:0] slot_t;
endpackage

// File: rtl/acl_rx_frame_ctl.sv
module acl_rx_frame_ctl
  import acl_rx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sync_i,
  output logic  samp_o,
  output logic  slot_end_o,
  output logic  frame_end_o,
  output slot_t slot_o
);
  localparam logic [BIT_IW-1:0] TAG_LAST  = BIT_IW'(TAG_W - 1);
  localparam logic [BIT_IW-1:0] SLOT_LAST = BIT_IW'(SLOT_W - 1);
  localparam slot_t             SLOT_MAX  = SLOT_IW'(N_SLOT);

  logic              sync_q, active_q, rise;
  slot_t             slot_q;
  logic [BIT_IW-1:0] bit_q, last_bit;

  assign rise        = sync_i & ~sync_q;
  assign samp_o      = active_q & ~rise;
  assign last_bit    = (slot_q == '0) ? TAG_LAST : SLOT_LAST;
  assign slot_end_o  = samp_o && (bit_q == last_bit);
  assign frame_end_o = slot_end_o && (slot_q == SLOT_MAX);
  assign slot_o      = slot_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= 1'b0;
      active_q <= 1'b0;
      slot_q   <= '0;
      bit_q    <= '0;
    end else begin
      sync_q <= sync_i;
      if (rise) begin
        active_q <= 1'b1;
        slot_q   <= '0;
        bit_q    <= '0;
      end else if (samp_o) begin
        if (bit_q == last_bit) begin
          bit_q  <= '0;
          slot_q <= (slot_q == SLOT_MAX) ? '0 : slot_q + 1'b1;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  // R9
  wrap_to_tag_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (frame_end_o && !sync_i) |=> (slot_o == '0));
endmodule

// File: rtl/acl_rx_deser.sv
module acl_rx_deser
  import acl_rx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  sdi_i,
  output word_t word_o
);
  word_t shift_q;

  assign word_o = {shift_q[SLOT_W-2:0], sdi_i};

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   shift_q <= '0;
    else if (en_i) shift_q <= word_o;
  end
endmodule

// File: rtl/acl_rx_merge.sv
module acl_rx_merge
  import acl_rx_pkg::*;
#(
  parameter int N_LINE = 2,
  parameter int LINE_W = 1
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               slot_end_i,
  input  logic                               frame_end_i,
  input  slot_t                              slot_i,
  input  word_t [N_LINE-1:0]                 word_i,
  output logic  [N_LINE-1:0]                 rdy_o,
  output logic                               col_err_o,
  output logic  [N_PCM-1:0]                  pcm_stb_o,
  output logic  [N_PCM-1:0][SLOT_W-1:0]      pcm_word_o,
  output logic  [N_PCM-1:0][LINE_W-1:0]      pcm_line_o,
  output logic                               stat_stb_o,
  output logic  [IDX_W-1:0]                  stat_idx_o,
  output logic  [STAT_W-1:0]                 stat_data_o,
  output logic  [N_PCM-1:0]                  req_n_o
);
  logic [N_LINE-1:0][N_SLOT:0] tag_q;
  logic [N_SLOT:1]             vld_q, vld_nxt;
  word_t                       word_q [1:N_SLOT];
  logic [LINE_W-1:0]           line_q [1:N_SLOT];
  logic [N_LINE-1:0]           hits;
  logic [LINE_W-1:0]           owner;
  logic                        any_hit, clash, tag_end, data_end;
  logic                        col_q, sstb_q;
  logic [N_PCM-1:0]            stb_q, req_q;
  logic                        unused_bits;

  assign tag_end  = slot_end_i && (slot_i == '0);
  assign data_end = slot_end_i && (slot_i != '0);

  always_comb begin
    for (int l = 0; l < N_LINE; l++) hits[l] = tag_q[l][slot_i];
    owner = '0;
    for (int l = N_LINE - 1; l >= 0; l--) if (hits[l]) owner = LINE_W'(l);
  end

  assign any_hit = |hits;
  assign clash   = $countones(hits) > 1;

  always_comb begin
    vld_nxt = vld_q;
    if (data_end) vld_nxt[slot_i] = any_hit;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q  <= '0;
      vld_q  <= '0;
      col_q  <= 1'b0;
      stb_q  <= '0;
      sstb_q <= 1'b0;
      req_q  <= '1;
      for (int k = 1; k <= N_SLOT; k++) begin
        word_q[k] <= '0;
        line_q[k] <= '0;
      end
    end else begin
      stb_q  <= frame_end_i ? vld_nxt[N_SLOT:PCM_LO] : '0;
      sstb_q <= frame_end_i & vld_nxt[1] & vld_nxt[2];
      if (frame_end_i && vld_nxt[1])
        for (int i = 0; i < N_PCM; i++) req_q[i] <= word_q[1][REQ_HI-i];
      if (tag_end) begin
        for (int l = 0; l < N_LINE; l++)
          for (int k = 0; k <= N_SLOT; k++) tag_q[l][k] <= word_i[l][TAG_W-1-k];
        vld_q <= '0;
      end
      if (data_end) begin
        vld_q <= vld_nxt;
        if (any_hit) begin
          word_q[slot_i] <= word_i[owner];
          line_q[slot_i] <= owner;
        end
        if (clash) col_q <= 1'b1;
      end
    end
  end

  always_comb begin
    for (int l = 0; l < N_LINE; l++) rdy_o[l] = tag_q[l][0];
    for (int i = 0; i < N_PCM; i++) begin
      pcm_word_o[i] = word_q[PCM_LO+i];
      pcm_line_o[i] = line_q[PCM_LO+i];
    end
  end

  assign col_err_o   = col_q;
  assign pcm_stb_o   = stb_q;
  assign stat_stb_o  = sstb_q;
  assign stat_idx_o  = word_q[1][IDX_HI -: IDX_W];
  assign stat_data_o = word_q[2][SLOT_W-1 -: STAT_W];
  assign req_n_o     = req_q;
  assign unused_bits = ^{word_q[1][SLOT_W-1], word_q[1][REQ_LO-1:0], word_q[2][STAT_LO-1:0]};

  // R4
  stb_at_frame_end_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (|pcm_stb_o) |-> $past(frame_end_i));
  // R6
  col_sticky_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    col_err_o |=> col_err_o);
  // R7
  stat_at_frame_end_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    stat_stb_o |-> $past(frame_end_i));
endmodule

// File: rtl/acl_rx.sv
module acl_rx
  import acl_rx_pkg::*;
#(
  parameter  int N_LINE = 2,
  localparam int LINE_W = (N_LINE > 1) ? $clog2(N_LINE) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sync_i,
  input  logic [N_LINE-1:0]          sdi_i,
  output logic [N_LINE-1:0]          rdy_o,
  output logic                       col_err_o,
  output logic [N_PCM-1:0]           pcm_stb_o,
  output logic [N_PCM*SLOT_W-1:0]    pcm_word_o,
  output logic [N_PCM*LINE_W-1:0]    pcm_line_o,
  output logic                       stat_stb_o,
  output logic [IDX_W-1:0]           stat_idx_o,
  output logic [STAT_W-1:0]          stat_data_o,
  output logic [N_PCM-1:0]           req_n_o
);
  logic               samp, slot_end, frame_end;
  slot_t              slot;
  word_t [N_LINE-1:0] line_word;

  acl_rx_frame_ctl u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_i      (sync_i),
    .samp_o      (samp),
    .slot_end_o  (slot_end),
    .frame_end_o (frame_end),
    .slot_o      (slot)
  );

  for (genvar g = 0; g < N_LINE; g++) begin : g_line
    acl_rx_deser u_deser (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (samp),
      .sdi_i  (sdi_i[g]),
      .word_o (line_word[g])
    );
  end

  acl_rx_merge #(.N_LINE(N_LINE), .LINE_W(LINE_W)) u_merge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slot_end_i  (slot_end),
    .frame_end_i (frame_end),
    .slot_i      (slot),
    .word_i      (line_word),
    .rdy_o       (rdy_o),
    .col_err_o   (col_err_o),
    .pcm_stb_o   (pcm_stb_o),
    .pcm_word_o  (pcm_word_o),
    .pcm_line_o  (pcm_line_o),
    .stat_stb_o  (stat_stb_o),
    .stat_idx_o  (stat_idx_o),
    .stat_data_o (stat_data_o),
    .req_n_o     (req_n_o)
  );

  // R3
  rdy_after_tag_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !$stable(rdy_o) |-> $past(slot_end && slot == '0));
  // R8
  req_at_frame_end_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !$stable(req_n_o) |-> $past(frame_end));
endmodule

// File: tb/acl_rx_test.sv
module acl_rx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync = 1'b0;
  logic [1:0] sdi = 2'b00;
  logic [1:0]   rdy;
  logic         col_err, stat_stb;
  logic [9:0]   pcm_stb, pcm_line, req_n;
  logic [199:0] pcm_word;
  logic [6:0]   stat_idx;
  logic [15:0]  stat_data;

  always #2 clk = ~clk;

  acl_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .sdi_i(sdi),
    .rdy_o(rdy), .col_err_o(col_err), .pcm_stb_o(pcm_stb),
    .pcm_word_o(pcm_word), .pcm_line_o(pcm_line), .stat_stb_o(stat_stb),
    .stat_idx_o(stat_idx), .stat_data_o(stat_data), .req_n_o(req_n)
  );

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;

  logic [1:0]  exp_rdy = '0;
  logic        exp_err = 1'b0, exp_sstb = 1'b0;
  logic [9:0]  exp_stb = '0, exp_line = '0, exp_req = '1;
  logic [19:0] exp_word [10];
  logic [6:0]  exp_idx = '0;
  logic [15:0] exp_sdata = '0;

  logic [15:0] ftag [2];
  logic [19:0] fw [2][13];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (mon_on) begin
      chk(rdy === exp_rdy, "R3 ready flags", rdy, exp_rdy);
      chk(col_err === exp_err, "R6 collision flag", col_err, exp_err);
      chk(pcm_stb === exp_stb, "R4 audio strobes", pcm_stb, exp_stb);
      chk(stat_stb === exp_sstb, "R7 status strobe", stat_stb, exp_sstb);
      chk(req_n === exp_req, "R8 slot requests", req_n, exp_req);
      for (int i = 0; i < 10; i++) begin
        if (exp_stb[i]) begin
          chk(pcm_word[i*20 +: 20] === exp_word[i], "R2 audio word", pcm_word[i*20 +: 20], exp_word[i]);
          chk(pcm_line[i] === exp_line[i], "R5 source line", pcm_line[i], exp_line[i]);
        end
      end
      if (exp_sstb) begin
        chk(stat_idx === exp_idx, "R7 register index", stat_idx, exp_idx);
        chk(stat_data === exp_sdata, "R7 status data", stat_data, exp_sdata);
      end
    end
  end

  task automatic drive_bit(input logic b0, input logic b1, input logic s);
    @(posedge clk);
    sdi  <= {b1, b0};
    sync <= s;
    @(negedge clk);
    #1;
    exp_stb  = '0;
    exp_sstb = 1'b0;
  endtask

  // t[11] tags slot 1 ... t[0] tags slot 12; untagged slots are zero
  task automatic mk_line(input int l, input logic r, input logic [11:0] t);
    ftag[l] = {r, t, 3'b000};
    fw[l][0] = '0;
    for (int k = 1; k <= 12; k++) fw[l][k] = t[12-k] ? 20'($urandom) : 20'h0;
  endtask

  task automatic frame_end_model();
    logic v0, v1;
    int o1, o2;
    for (int k = 3; k <= 12; k++) begin
      v0 = ftag[0][15-k];
      v1 = ftag[1][15-k];
      exp_stb[k-3]  = v0 | v1;
      exp_word[k-3] = v0 ? fw[0][k] : fw[1][k];
      exp_line[k-3] = v0 ? 1'b0 : 1'b1;
    end
    o1 = ftag[0][14] ? 0 : 1;
    o2 = ftag[0][13] ? 0 : 1;
    if (ftag[0][14] | ftag[1][14]) begin
      for (int i = 0; i < 10; i++) exp_req[i] = fw[o1][1][11-i];
      if (ftag[0][13] | ftag[1][13]) begin
        exp_sstb  = 1'b1;
        exp_idx   = fw[o1][1][18:12];
        exp_sdata = fw[o2][2][19:4];
      end
    end
  endtask

  task automatic send_frame(input bit with_sync, input int nbits);
    logic b [2];
    int k, j;
    if (with_sync) drive_bit(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < nbits; i++) begin
      for (int l = 0; l < 2; l++) begin
        if (i < 16) b[l] = ftag[l][15-i];
        else begin
          k = (i - 16) / 20 + 1;
          j = (i - 16) % 20;
          b[l] = fw[l][k][19-j];
        end
      end
      drive_bit(b[0], b[1], with_sync && (i < 15));
      if (i == 15) exp_rdy = {ftag[1][15], ftag[0][15]};
      if (i >= 16 && ((i - 15) % 20) == 0) begin
        k = (i - 15) / 20;
        if (ftag[0][15-k] & ftag[1][15-k]) exp_err = 1'b1; // R6
      end
      if (i == 255) frame_end_model();
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [11:0] r0, r1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R10 reset state
    chk(rdy === 2'b00 && col_err === 1'b0, "R10 reset flags", {rdy, col_err}, 0);
    chk(pcm_stb === '0 && stat_stb === 1'b0, "R10 reset strobes", {pcm_stb, stat_stb}, 0);
    chk(req_n === 10'h3ff && pcm_line === '0, "R10 reset requests", {req_n, pcm_line}, 20'h3ff << 10);
    mon_on = 1'b1;

    // R1: busy data lines before any sync are not captured
    for (int i = 0; i < 40; i++) drive_bit(1'b1, 1'b1, 1'b0);
    chk(rdy === 2'b00, "R1 no capture before sync", rdy, 0);

    // primary owns slots 1..4, secondary owns 5..12
    mk_line(0, 1'b1, 12'b1111_0000_0000);
    mk_line(1, 1'b1, 12'b0000_1111_1111);
    send_frame(1'b1, 256);

    // R9: next frame follows directly with no sync edge; secondary owns 1..3
    mk_line(0, 1'b0, 12'b0000_0100_0000);
    mk_line(1, 1'b1, 12'b1110_0000_0001);
    send_frame(1'b0, 256);

    // R6: collision on slot 12 lands on the frame-end edge
    drive_bit(1'b0, 1'b0, 1'b0);
    drive_bit(1'b0, 1'b0, 1'b0);
    mk_line(0, 1'b1, 12'b1100_0000_0001);
    mk_line(1, 1'b1, 12'b0000_0010_0001);
    send_frame(1'b1, 256);
    chk(col_err === 1'b1, "R6 collision sticky", col_err, 1);

    // R1: realignment discards a partial frame
    mk_line(0, 1'b1, 12'b0011_1000_0000);
    mk_line(1, 1'b0, 12'b0000_0000_0000);
    send_frame(1'b1, 120);
    chk(pcm_stb === '0, "R1 partial frame gives no strobe", pcm_stb, 0);
    mk_line(0, 1'b1, 12'b0010_0000_0000);
    mk_line(1, 1'b1, 12'b0001_0000_0000);
    send_frame(1'b1, 256);

    // R8: frame with nothing valid keeps requests
    mk_line(0, 1'b0, 12'h000);
    mk_line(1, 1'b0, 12'h000);
    send_frame(1'b0, 256);

    // disjoint random tag sets
    for (int n = 0; n < 6; n++) begin
      r0 = 12'($urandom);
      r1 = 12'($urandom) & ~r0;
      mk_line(0, 1'($urandom), r0);
      mk_line(1, 1'($urandom), r1);
      send_frame(n[0], 256);
    end
    drive_bit(1'b0, 1'b0, 1'b0);
    drive_bit(1'b0, 1'b0, 1'b0);
    finish_run();
  end
endmodule